// File: doc/BRIEF.md
# Banked Dual-Port Byte Memory

This block is a synchronous byte-wide memory with two fully independent access ports, a left and a right. Both ports share one clock, but each has its own address, write data, read data, chip select, semaphore select, read/write line and output enable. The storage is split into several equal dual-port banks. On each port, the upper address bits pick one bank through a one-hot decode, and the lower bits pick a word inside that bank.

Each port decodes its own control pins into a mode: idle (deselected), write, read, outputs disabled, or a semaphore access. A semaphore access is not served by the memory. It is flagged on a per-port request output for a separate semaphore unit. A build parameter fills only the lower half of the banks. In that variant, any access whose top address bit is set finds no bank.

Read data is registered, so it appears one clock after the request together with a valid flag. Nothing arbitrates between the ports. A read that meets a same-cycle write to the same word returns the old contents. When both ports write the same word in the same cycle, the left port's data is the data kept.

Top module: `dpmem_banked`

## Requirements
- R1: With chip select low (0), semaphore select high (1) and read/write low (0), the port writes its write data at its address. The output enable has no effect on a write.
- R2: With chip select low, semaphore select high, read/write high (1) and output enable low (0), the port reads. Read valid is high on the next clock, and read data then holds the word at the requested address.
- R3: With chip select high and semaphore select high, the port is idle. Nothing is written, and on the next clock read valid is 0 and read data is 0.
- R4: With chip select low, semaphore select high, read/write high and output enable high, the outputs are disabled. On the next clock read valid is 0 and read data is 0.
- R5: The top BANK_BITS address bits select exactly one bank and the low WORD_BITS bits select the word. Addresses that share low bits but differ in bank bits hold separate values.
- R6: A word written on one port is readable on the other port one clock later. A read of the same word in the same cycle as the write returns the old contents.
- R7: When both ports write the same word in the same cycle, the left port's data is kept. Same-cycle writes from both ports to different words both take effect.
- R8: With chip select high and semaphore select low, the port's semaphore request output is high in that same cycle. Its semaphore write output equals the inverted read/write line. The memory is untouched, and read valid is 0 on the next clock.
- R9: With chip select low and semaphore select low, the combination is not allowed and is ignored. There is no semaphore request and no write, and read valid is 0 on the next clock.
- R10: With HALF_POP=1, only the lower half of the banks exist. An access with the top address bit set writes nothing, does not alias a lower bank, and gives read valid 0.
- R11: After reset, both read valid outputs are 0 and both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low reset of the read pipeline |
| l_cs_n | input | 1 | Left chip select, active low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_rw | input | 1 | Left read/write: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W (7) | Left address: bank bits on top, word bits below |
| l_wdata | input | DATA_W (8) | Left write data |
| l_rdata | output | DATA_W (8) | Left registered read data, 0 when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_sem_req | output | 1 | Left semaphore access request |
| l_sem_wr | output | 1 | Left semaphore access is a write |
| r_cs_n | input | 1 | Right chip select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_rw | input | 1 | Right read/write: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W (7) | Right address |
| r_wdata | input | DATA_W (8) | Right write data |
| r_rdata | output | DATA_W (8) | Right registered read data, 0 when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_sem_req | output | 1 | Right semaphore access request |
| r_sem_wr | output | 1 | Right semaphore access is a write |

## Verification
A wrong bank decode shows up as aliasing. A word written through one bank reads back through another, or it is overwritten by a write that should have gone elsewhere. This appears on the first cross-bank read after the offending write, one clock after the read request. A wrong mode decode shows at once: semaphore request outputs appear in the same cycle, and a read valid that is wrongly high or low appears on the next clock. A lost write priority or a missing same-cycle read-before-write rule changes the data read back one clock after the colliding access.

// File: rtl/dpmem_pkg.sv
package dpmem_pkg;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_WRITE = 3'd1,
    MD_READ  = 3'd2,
    MD_OFF   = 3'd3,
    MD_SEM   = 3'd4,
    MD_BAD   = 3'd5
  } port_mode_e;

  function automatic port_mode_e mode_of(input logic cs_n, input logic sem_n,
                                         input logic rw, input logic oe_n);
    port_mode_e m;
    if (cs_n && sem_n)        m = MD_IDLE;
    else if (!cs_n && !sem_n) m = MD_BAD;
    else if (cs_n)            m = MD_SEM;
    else if (!rw)             m = MD_WRITE;
    else if (oe_n)            m = MD_OFF;
    else                      m = MD_READ;
    return m;
  endfunction

endpackage

// File: rtl/dpmem_port_decode.sv
module dpmem_port_decode
  import dpmem_pkg::*;
#(
  parameter int BANK_BITS = 3,
  parameter int WORD_BITS = 4,
  parameter int POP_BANKS = 8,
  localparam int NBANK  = 1 << BANK_BITS,
  localparam int ADDR_W = BANK_BITS + WORD_BITS
) (
  input  logic                 cs_n,
  input  logic                 sem_n,
  input  logic                 rw,
  input  logic                 oe_n,
  input  logic [ADDR_W-1:0]    addr,
  output port_mode_e           mode,
  output logic [NBANK-1:0]     bank_sel,
  output logic [BANK_BITS-1:0] bank_idx,
  output logic [WORD_BITS-1:0] word,
  output logic                 hit,
  output logic                 mem_we,
  output logic                 mem_rd,
  output logic                 sem_req,
  output logic                 sem_wr
);

  logic mem_mode;

  assign mode     = mode_of(cs_n, sem_n, rw, oe_n);
  assign bank_idx = addr[ADDR_W-1 -: BANK_BITS];
  assign word     = addr[WORD_BITS-1:0];
  assign hit      = (32'(bank_idx) < POP_BANKS);
  assign mem_mode = (mode == MD_WRITE) || (mode == MD_READ);
  assign mem_we   = (mode == MD_WRITE) && hit;
  assign mem_rd   = (mode == MD_READ) && hit;
  assign sem_req  = (mode == MD_SEM);
  assign sem_wr   = sem_req && !rw;

  for (genvar g = 0; g < NBANK; g++) begin : g_sel
    if (g < POP_BANKS) begin : g_pop
      assign bank_sel[g] = mem_mode && (32'(bank_idx) == g);
    end else begin : g_empty
      assign bank_sel[g] = 1'b0;
    end
  end

endmodule

// File: rtl/dpmem_bank.sv
module dpmem_bank #(
  parameter int DATA_W    = 8,
  parameter int WORD_BITS = 4,
  localparam int DEPTH = 1 << WORD_BITS
) (
  input  logic                 clk,
  input  logic                 l_we,
  input  logic [WORD_BITS-1:0] l_word,
  input  logic [DATA_W-1:0]    l_wd,
  output logic [DATA_W-1:0]    l_rd,
  input  logic                 r_we,
  input  logic [WORD_BITS-1:0] r_word,
  input  logic [DATA_W-1:0]    r_wd,
  output logic [DATA_W-1:0]    r_rd
);

  logic [DATA_W-1:0] store [DEPTH];

  // The right write is scheduled first so a colliding left write lands last.
  always_ff @(posedge clk) begin
    if (r_we) store[r_word] <= r_wd;
    if (l_we) store[l_word] <= l_wd;
    l_rd <= store[l_word];
    r_rd <= store[r_word];
  end

endmodule

// File: rtl/dpmem_banked.sv
module dpmem_banked
  import dpmem_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BANK_BITS = 3,
  parameter int WORD_BITS = 4,
  parameter bit HALF_POP  = 1'b0,
  localparam int NBANK     = 1 << BANK_BITS,
  localparam int POP_BANKS = HALF_POP ? NBANK / 2 : NBANK,
  localparam int ADDR_W    = BANK_BITS + WORD_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_sem_n,
  input  logic              l_rw,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_sem_req,
  output logic              l_sem_wr,
  input  logic              r_cs_n,
  input  logic              r_sem_n,
  input  logic              r_rw,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_sem_req,
  output logic              r_sem_wr
);

  port_mode_e           l_mode, r_mode;
  logic [NBANK-1:0]     l_sel, r_sel;
  logic [BANK_BITS-1:0] l_idx, r_idx, l_idx_q, r_idx_q;
  logic [WORD_BITS-1:0] l_word, r_word;
  logic                 l_hit, r_hit, l_mem_we, r_mem_we, l_mem_rd, r_mem_rd;
  logic [DATA_W-1:0]    l_bank_rd [NBANK];
  logic [DATA_W-1:0]    r_bank_rd [NBANK];

  dpmem_port_decode #(.BANK_BITS(BANK_BITS), .WORD_BITS(WORD_BITS), .POP_BANKS(POP_BANKS)) u_dec_l (
    .cs_n(l_cs_n), .sem_n(l_sem_n), .rw(l_rw), .oe_n(l_oe_n), .addr(l_addr),
    .mode(l_mode), .bank_sel(l_sel), .bank_idx(l_idx), .word(l_word), .hit(l_hit),
    .mem_we(l_mem_we), .mem_rd(l_mem_rd), .sem_req(l_sem_req), .sem_wr(l_sem_wr));

  dpmem_port_decode #(.BANK_BITS(BANK_BITS), .WORD_BITS(WORD_BITS), .POP_BANKS(POP_BANKS)) u_dec_r (
    .cs_n(r_cs_n), .sem_n(r_sem_n), .rw(r_rw), .oe_n(r_oe_n), .addr(r_addr),
    .mode(r_mode), .bank_sel(r_sel), .bank_idx(r_idx), .word(r_word), .hit(r_hit),
    .mem_we(r_mem_we), .mem_rd(r_mem_rd), .sem_req(r_sem_req), .sem_wr(r_sem_wr));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (b < POP_BANKS) begin : g_pop
      dpmem_bank #(.DATA_W(DATA_W), .WORD_BITS(WORD_BITS)) u_bank (
        .clk(clk),
        .l_we(l_sel[b] && l_mem_we), .l_word(l_word), .l_wd(l_wdata), .l_rd(l_bank_rd[b]),
        .r_we(r_sel[b] && r_mem_we), .r_word(r_word), .r_wd(r_wdata), .r_rd(r_bank_rd[b]));
    end else begin : g_empty
      assign l_bank_rd[b] = '0;
      assign r_bank_rd[b] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rvalid <= 1'b0;
      r_rvalid <= 1'b0;
      l_idx_q  <= '0;
      r_idx_q  <= '0;
    end else begin
      l_rvalid <= l_mem_rd;
      r_rvalid <= r_mem_rd;
      l_idx_q  <= l_idx;
      r_idx_q  <= r_idx;
    end
  end

  assign l_rdata = l_rvalid ? l_bank_rd[l_idx_q] : '0;
  assign r_rdata = r_rvalid ? r_bank_rd[r_idx_q] : '0;

  // R2: a valid flag only follows a read request on the previous clock
  assert_rvalid_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    l_rvalid |-> $past(l_mem_rd));
  // R3: idle port gives no data next clock
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_mode == MD_IDLE) |=> !r_rvalid);
  // R4: disabled outputs stay low next clock
  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_mode == MD_OFF) |=> (!l_rvalid && l_rdata == '0));
  // R5: at most one bank is selected per port
  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_sel) && $onehot0(r_sel));
  // R8: a semaphore access never touches the memory
  assert_sem_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sem_req || r_sem_req) |-> !((l_sem_req && (l_mem_we || l_mem_rd)) ||
                                   (r_sem_req && (r_mem_we || r_mem_rd))));
  // R9: both selects low is ignored
  assert_bad_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_mode == MD_BAD) |-> (!l_sem_req && l_sel == '0));
  // R10: a missing bank is never selected
  assert_empty_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_hit || !r_hit) |-> ((l_hit || l_sel == '0) && (r_hit || r_sel == '0)));

endmodule

// File: tb/sim_dpmem_banked.sv
module sim_dpmem_banked;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          l_cs_n = 1, l_sem_n = 1, l_rw = 1, l_oe_n = 1;
  logic          r_cs_n = 1, r_sem_n = 1, r_rw = 1, r_oe_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata, h_rdata, h_unused_rd;
  logic          l_rvalid, r_rvalid, l_sem_req, l_sem_wr, r_sem_req, r_sem_wr;
  logic          h_rvalid, h_unused_rv, h_sq, h_sw, h_sq2, h_sw2;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpmem_banked u0 (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_sem_n(l_sem_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_sem_req(l_sem_req), .l_sem_wr(l_sem_wr),
    .r_cs_n(r_cs_n), .r_sem_n(r_sem_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_sem_req(r_sem_req), .r_sem_wr(r_sem_wr));

  // half-populated variant, driven by the left-port stimulus
  dpmem_banked #(.HALF_POP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_sem_n(l_sem_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(h_rdata), .l_rvalid(h_rvalid), .l_sem_req(h_sq), .l_sem_wr(h_sw),
    .r_cs_n(1'b1), .r_sem_n(1'b1), .r_rw(1'b1), .r_oe_n(1'b1), .r_addr('0),
    .r_wdata('0), .r_rdata(h_unused_rd), .r_rvalid(h_unused_rv), .r_sem_req(h_sq2), .r_sem_wr(h_sw2));

  // {address, data}; the addresses span all eight banks
  localparam logic [14:0] VEC [8] = '{
    {7'h00, 8'h11}, {7'h10, 8'h22}, {7'h25, 8'h33}, {7'h3F, 8'h44},
    {7'h4A, 8'h55}, {7'h51, 8'h66}, {7'h6E, 8'h77}, {7'h7F, 8'h88}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drv_l(input logic cs_n, input logic sem_n, input logic rw, input logic oe_n,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_cs_n = cs_n; l_sem_n = sem_n; l_rw = rw; l_oe_n = oe_n; l_addr = a; l_wdata = d;
  endtask

  task automatic drv_r(input logic cs_n, input logic sem_n, input logic rw, input logic oe_n,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_cs_n = cs_n; r_sem_n = sem_n; r_rw = rw; r_oe_n = oe_n; r_addr = a; r_wdata = d;
  endtask

  task automatic idle_both();
    drv_l(1, 1, 1, 1, '0, '0);
    drv_r(1, 1, 1, 1, '0, '0);
  endtask

  // read one word on the right port; result is visible after one step
  task automatic read_r(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    drv_r(0, 1, 1, 0, a, '0);
    drv_l(1, 1, 1, 1, '0, '0);
    step();
    chk(r_rvalid === 1'b1, tag, int'(r_rvalid), 1);
    chk(r_rdata === exp, tag, int'(r_rdata), int'(exp));
    idle_both();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_both();
    repeat (3) step();
    // R11: reset state
    chk(l_rvalid === 0 && r_rvalid === 0, "R11 rvalid after reset", int'({l_rvalid, r_rvalid}), 0);
    chk(l_rdata === 0 && r_rdata === 0, "R11 rdata after reset", int'({l_rdata, r_rdata}), 0);
    rst_n = 1'b1;
    step();

    // R1, R2, R6: vector table, written on the left and read on the right
    foreach (VEC[i]) begin
      drv_l(0, 1, 0, i % 2, VEC[i][14:8], VEC[i][7:0]);
      step();
      idle_both();
      read_r(VEC[i][14:8], VEC[i][7:0], "R1/R2/R6 vector write-read");
    end
    // R1/R2: left-port read of a vector word
    drv_l(0, 1, 1, 0, 7'h3F, '0);
    step();
    chk(l_rvalid === 1 && l_rdata === 8'h44, "R2 left read", int'(l_rdata), 'h44);
    idle_both();

    // R5: same low bits, different banks
    drv_l(0, 1, 0, 1, 7'h03, 8'hA1); step();
    drv_l(0, 1, 0, 1, 7'h13, 8'hB2); step();
    drv_l(0, 1, 0, 1, 7'h73, 8'hC3); step();
    idle_both();
    read_r(7'h03, 8'hA1, "R5 bank 0 word 3");
    read_r(7'h13, 8'hB2, "R5 bank 1 word 3");
    read_r(7'h73, 8'hC3, "R5 bank 7 word 3");

    // R3: deselected write attempt
    drv_l(1, 1, 0, 1, 7'h00, 8'hFF);
    step();
    chk(l_rvalid === 0 && l_rdata === 0, "R3 idle outputs", int'(l_rdata), 0);
    idle_both();
    read_r(7'h00, 8'h11, "R3 idle wrote nothing");

    // R4: outputs disabled
    drv_r(0, 1, 1, 1, 7'h10, '0);
    step();
    chk(r_rvalid === 0, "R4 rvalid disabled", int'(r_rvalid), 0);
    chk(r_rdata === 0, "R4 rdata disabled", int'(r_rdata), 0);
    idle_both();

    // R6: same-cycle write left and read right of one word returns old data
    drv_l(0, 1, 0, 1, 7'h10, 8'h99);
    drv_r(0, 1, 1, 0, 7'h10, '0);
    step();
    chk(r_rvalid === 1 && r_rdata === 8'h22, "R6 read-before-write", int'(r_rdata), 'h22);
    idle_both();
    read_r(7'h10, 8'h99, "R6 new data next read");

    // R7: both ports write one word; left wins
    drv_l(0, 1, 0, 1, 7'h25, 8'hAA);
    drv_r(0, 1, 0, 1, 7'h25, 8'hBB);
    step();
    idle_both();
    read_r(7'h25, 8'hAA, "R7 left wins collision");
    // R7: both ports write different words
    drv_l(0, 1, 0, 1, 7'h51, 8'h5C);
    drv_r(0, 1, 0, 1, 7'h6E, 8'h6D);
    step();
    idle_both();
    read_r(7'h51, 8'h5C, "R7 left distinct write");
    read_r(7'h6E, 8'h6D, "R7 right distinct write");

    // R8: semaphore write on the left
    drv_l(1, 0, 0, 1, 7'h3F, 8'h5A);
    #1;
    chk(l_sem_req === 1 && l_sem_wr === 1, "R8 sem write request", int'({l_sem_req, l_sem_wr}), 3);
    step();
    chk(l_rvalid === 0, "R8 no read data", int'(l_rvalid), 0);
    // R8: semaphore read on the right
    drv_l(1, 1, 1, 1, '0, '0);
    drv_r(1, 0, 1, 0, 7'h3F, '0);
    #1;
    chk(r_sem_req === 1 && r_sem_wr === 0, "R8 sem read request", int'({r_sem_req, r_sem_wr}), 2);
    step();
    chk(r_rvalid === 0, "R8 sem read no data", int'(r_rvalid), 0);
    idle_both();
    read_r(7'h3F, 8'h44, "R8 memory untouched");

    // R9: both selects low
    drv_l(0, 0, 0, 0, 7'h4A, 8'hFF);
    #1;
    chk(l_sem_req === 0, "R9 no sem request", int'(l_sem_req), 0);
    step();
    chk(l_rvalid === 0, "R9 no read data", int'(l_rvalid), 0);
    idle_both();
    read_r(7'h4A, 8'h55, "R9 no write");

    // R10: half-populated variant
    drv_l(0, 1, 0, 1, 7'h05, 8'h77); step();
    drv_l(0, 1, 0, 1, 7'h45, 8'h33); step();
    drv_l(0, 1, 1, 0, 7'h45, '0);
    step();
    chk(h_rvalid === 0 && h_rdata === 0, "R10 empty bank read", int'(h_rdata), 0);
    drv_l(0, 1, 1, 0, 7'h05, '0);
    step();
    chk(h_rvalid === 1 && h_rdata === 8'h77, "R10 no aliasing", int'(h_rdata), 'h77);
    idle_both();
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule